// File: doc/BRIEF.md
# Multi-lane serial I/O width controller

This block is the lane front end between the serial pins of a memory-style slave port and a byte-oriented command engine. It samples the serial clock and the active-low select in its own system clock domain. It packs incoming lane bits into bytes and hands each byte to the engine with a one-cycle valid pulse. It also flags the first byte of every select frame, so the engine can treat that byte as the opcode.

The port can run one, two or four lanes wide. The active width is a register that keeps its value from one frame to the next. The first byte of a frame changes the width in three cases: a 0x3B in one-lane mode moves to two lanes, a 0x38 in one-lane mode moves to four lanes, and a 0xFF in any mode returns to one lane. For reads, the engine signals the start of the output phase, and the block may insert dummy clocks first, depending on the width. The block then takes bytes from the engine, shifts them out MSB first on the falling clock, and drives the output enable of each lane. In one- and two-lane modes, lane 3 acts as a pause input. In four-lane mode, lane 3 carries data.

Top module: `sio_lane_ctrl`

## Requirements
- R1: After reset, `lane_mode` is 0 (one lane), `lane_oe` is 0000 and `rx_valid` is low.
- R2: On each SCK rising edge, input bits are shifted in MSB first. One-lane mode uses lane 0 and takes 8 clocks per byte. Two-lane mode uses lanes 1:0, with lane 1 as the higher bit, and takes 4 clocks per byte. Four-lane mode uses lanes 3:0, with lane 3 as the highest bit, and takes 2 clocks per byte. Each byte gives exactly one `rx_valid` pulse, and `rx_first` is high only for the first byte of a frame.
- R3: A first byte of 0x3B received in one-lane mode sets `lane_mode` to 1 (two lanes). A first byte of 0x38 received in one-lane mode sets it to 2 (four lanes). The new width applies from the next SCK rising edge.
- R4: The width holds across frames. In two- and four-lane modes, only a first byte of 0xFF changes it, and it returns to 0. A 0x3B or 0x38 received in a wider mode has no effect. So does any of these codes when it is not the first byte of its frame.
- R5: After `dout_start`, each SCK falling edge drives the next chunk of the current byte, MSB first. The chunk is 1 bit on lane 1, 2 bits on lanes 1:0, or 4 bits on lanes 3:0. A new `tx_byte` is loaded at each byte boundary with a one-cycle `tx_take` pulse. `lane_oe` is 0010, 0011 or 1111 for the three widths.
- R6: When `dout_dummy` is high, the block skips 4 falling edges before data in two-lane mode, 2 in four-lane mode and none in one-lane mode. `lane_oe` stays 0000 during the skipped edges. When `dout_dummy` is low, no edges are skipped.
- R7: In one- and two-lane modes, a low on lane 3 sampled while SCK is low pauses the block until lane 3 returns high while SCK is low. During the pause, SCK edges have no effect and `lane_oe` is 0000. Once released, transfers resume where they stopped. In four-lane mode, a low on lane 3 is ordinary data.
- R8: With `cs_n` high, `lane_oe` is 0000 from the next clock on. A partly received byte is discarded and the output phase ends, but `lane_mode` keeps its value.
- R9: During the output phase, input lanes are ignored and no `rx_valid` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, runs faster than SCK |
| rst_n | input | 1 | Active-low reset (power-up state) |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| lane_in | input | 4 | Input values of the four data lanes |
| lane_out | output | 4 | Output values of the four data lanes |
| lane_oe | output | 4 | Per-lane output enable |
| lane_mode | output | 2 | Active width: 0 one lane, 1 two lanes, 2 four lanes |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_first | output | 1 | The strobed byte opens its frame |
| dout_start | input | 1 | Engine pulse that opens the output phase |
| dout_dummy | input | 1 | Apply the width-dependent dummy clocks |
| tx_byte | input | 8 | Next byte to send |
| tx_take | output | 1 | One-cycle pulse when `tx_byte` is loaded |

## Verification
Two events can fall in the same system clock. One is the width register update that follows an opcode byte. The other is the frame teardown caused by `cs_n` rising. The bench provokes this by raising select right after the last clock of each width-changing opcode. It then judges the outcome by the width reported afterwards and by packing the next frame at the new lane count. A second overlap occurs when a pause starts on the same falling edge that loads a new output byte. The bench judges it by checking that enables drop during the pause and that the byte stream continues without a gap once the pause ends.

// File: rtl/sio_lane_pkg.sv
package sio_lane_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [1:0] {
        WID_X1 = 2'd0,
        WID_X2 = 2'd1,
        WID_X4 = 2'd2
    } wid_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DUMMY = 2'd1,
        TX_DATA  = 2'd2
    } txst_e;

    // Bits moved per SCK edge for a width
    function automatic logic [2:0] step_of(wid_e w);
        case (w)
            WID_X2:  return 3'd2;
            WID_X4:  return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Lanes driven during output for a width
    function automatic logic [LANES-1:0] oe_of(wid_e w);
        case (w)
            WID_X2:  return 4'b0011;
            WID_X4:  return 4'b1111;
            default: return 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/sio_lane_rx.sv
module sio_lane_rx
    import sio_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clr,
    input  logic              rise,
    input  logic              enable,
    input  wid_e              wid,
    input  logic [LANES-1:0]  lane_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              first_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              first_pend;
        logic [BYTE_W-1:0] byte_r;
        logic              valid;
        logic              first;
    } rx_t;

    rx_t s_q, s_d;

    always_comb begin
        logic [BYTE_W-1:0] nxt;
        logic [CNT_W-1:0]  cnt_n;
        s_d       = s_q;
        s_d.valid = 1'b0;
        nxt       = s_q.sh;
        cnt_n     = s_q.cnt;
        if (frame_clr) begin
            s_d.sh         = '0;
            s_d.cnt        = '0;
            s_d.first_pend = 1'b1;
        end else if (rise && enable) begin
            case (wid)
                WID_X2:  nxt = {s_q.sh[BYTE_W-3:0], lane_in[1:0]};
                WID_X4:  nxt = {s_q.sh[BYTE_W-5:0], lane_in[3:0]};
                default: nxt = {s_q.sh[BYTE_W-2:0], lane_in[0]};
            endcase
            cnt_n  = s_q.cnt + CNT_W'(step_of(wid));
            s_d.sh = nxt;
            if (cnt_n >= CNT_W'(BYTE_W)) begin
                s_d.byte_r     = nxt;
                s_d.valid      = 1'b1;
                s_d.first      = s_q.first_pend;
                s_d.first_pend = 1'b0;
                s_d.cnt        = '0;
            end else begin
                s_d.cnt = cnt_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.first_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_o  = s_q.byte_r;
    assign valid_o = s_q.valid;
    assign first_o = s_q.first;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(BYTE_W));

    // R2
    byte_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rise && enable));

endmodule

// File: rtl/sio_lane_tx.sv
module sio_lane_tx
    import sio_lane_pkg::*;
#(
    parameter int DUMMY_X2 = 4,
    parameter int DUMMY_X4 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clr,
    input  logic              fall,
    input  logic              start,
    input  logic              dummy,
    input  wid_e              wid,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [LANES-1:0]  out_o,
    output logic [LANES-1:0]  oe_o,
    output logic              take_o,
    output logic              busy_o
);

    localparam int DMAX = (DUMMY_X2 > DUMMY_X4) ? DUMMY_X2 : DUMMY_X4;
    localparam int DC_W = $clog2(DMAX + 1) + 1;

    typedef struct packed {
        txst_e             st;
        logic [DC_W-1:0]   dcnt;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  rem;
        logic [LANES-1:0]  out;
        logic [LANES-1:0]  oe;
        logic              take;
    } tx_t;

    tx_t s_q, s_d;

    always_comb begin
        logic [DC_W-1:0]   dn;
        logic [BYTE_W-1:0] cur;
        logic [CNT_W-1:0]  rem_base;
        s_d      = s_q;
        s_d.take = 1'b0;
        cur      = s_q.sh;
        rem_base = s_q.rem;
        case (wid)
            WID_X2:  dn = DC_W'(DUMMY_X2);
            WID_X4:  dn = DC_W'(DUMMY_X4);
            default: dn = '0;
        endcase
        if (frame_clr) begin
            s_d.st   = TX_IDLE;
            s_d.oe   = '0;
            s_d.out  = '0;
            s_d.rem  = '0;
            s_d.dcnt = '0;
        end else if (start) begin
            s_d.oe  = '0;
            s_d.rem = '0;
            if (dummy && dn != '0) begin
                s_d.st   = TX_DUMMY;
                s_d.dcnt = dn;
            end else begin
                s_d.st = TX_DATA;
            end
        end else if (fall) begin
            case (s_q.st)
                TX_DUMMY: begin
                    if (s_q.dcnt <= DC_W'(1)) begin
                        s_d.st   = TX_DATA;
                        s_d.dcnt = '0;
                    end else begin
                        s_d.dcnt = s_q.dcnt - DC_W'(1);
                    end
                end
                TX_DATA: begin
                    if (s_q.rem == '0) begin
                        cur      = tx_byte;
                        rem_base = CNT_W'(BYTE_W);
                        s_d.take = 1'b1;
                    end
                    case (wid)
                        WID_X2: begin
                            s_d.out = {2'b00, cur[BYTE_W-1:BYTE_W-2]};
                            s_d.sh  = cur << 2;
                        end
                        WID_X4: begin
                            s_d.out = cur[BYTE_W-1:BYTE_W-4];
                            s_d.sh  = cur << 4;
                        end
                        default: begin
                            s_d.out = {2'b00, cur[BYTE_W-1], 1'b0};
                            s_d.sh  = cur << 1;
                        end
                    endcase
                    s_d.rem = rem_base - CNT_W'(step_of(wid));
                    s_d.oe  = oe_of(wid);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= TX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_o  = s_q.out;
    assign oe_o   = s_q.oe;
    assign take_o = s_q.take;
    assign busy_o = (s_q.st != TX_IDLE);

    // R6
    dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_DUMMY) |-> (oe_o == '0));

    // R5
    take_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(fall));

    // R5
    oe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});

endmodule

// File: rtl/sio_lane_width.sv
module sio_lane_width
    import sio_lane_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OP_X1 = 8'hFF,
    parameter logic [BYTE_W-1:0] OP_X2 = 8'h3B,
    parameter logic [BYTE_W-1:0] OP_X4 = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              byte_first,
    input  logic [BYTE_W-1:0] byte_in,
    output wid_e              wid_o
);

    typedef struct packed {
        wid_e wid;
    } wc_t;

    wc_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (byte_valid && byte_first) begin
            if (s_q.wid == WID_X1) begin
                if (byte_in == OP_X2)      s_d.wid = WID_X2;
                else if (byte_in == OP_X4) s_d.wid = WID_X4;
            end else if (byte_in == OP_X1) begin
                s_d.wid = WID_X1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.wid <= WID_X1;
        else        s_q     <= s_d;
    end

    assign wid_o = s_q.wid;

    // R4
    width_opcode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wid != $past(s_q.wid)) |-> $past(byte_valid && byte_first));

    // R3
    width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wid != 2'd3);

endmodule

// File: rtl/sio_lane_ctrl.sv
module sio_lane_ctrl
    import sio_lane_pkg::*;
#(
    parameter int          DUMMY_X2 = 4,
    parameter int          DUMMY_X4 = 2,
    parameter logic [7:0]  OP_X1    = 8'hFF,
    parameter logic [7:0]  OP_X2    = 8'h3B,
    parameter logic [7:0]  OP_X4    = 8'h38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [3:0] lane_in,
    output logic [3:0] lane_out,
    output logic [3:0] lane_oe,
    output logic [1:0] lane_mode,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_first,
    input  logic       dout_start,
    input  logic       dout_dummy,
    input  logic [7:0] tx_byte,
    output logic       tx_take
);

    typedef struct packed {
        logic sck;
        logic hold;
    } edge_t;

    edge_t t_q, t_d;
    wid_e  wid;
    logic  rise, fall, active, tx_busy;
    logic [LANES-1:0] oe_raw;

    always_comb begin
        t_d     = t_q;
        t_d.sck = sck;
        if (cs_n) begin
            t_d.hold = 1'b0;
        end else if (!t_q.sck && !sck) begin
            t_d.hold = (wid != WID_X4) && !lane_in[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign active = !cs_n && !t_q.hold;
    assign rise   = active && sck && !t_q.sck;
    assign fall   = active && !sck && t_q.sck;

    sio_lane_width #(
        .OP_X1 (OP_X1),
        .OP_X2 (OP_X2),
        .OP_X4 (OP_X4)
    ) u_width (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_valid),
        .byte_first (rx_first),
        .byte_in    (rx_byte),
        .wid_o      (wid)
    );

    sio_lane_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_clr (cs_n),
        .rise      (rise),
        .enable    (!tx_busy),
        .wid       (wid),
        .lane_in   (lane_in),
        .byte_o    (rx_byte),
        .valid_o   (rx_valid),
        .first_o   (rx_first)
    );

    sio_lane_tx #(
        .DUMMY_X2 (DUMMY_X2),
        .DUMMY_X4 (DUMMY_X4)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_clr (cs_n),
        .fall      (fall),
        .start     (dout_start && !cs_n),
        .dummy     (dout_dummy),
        .wid       (wid),
        .tx_byte   (tx_byte),
        .out_o     (lane_out),
        .oe_o      (oe_raw),
        .take_o    (tx_take),
        .busy_o    (tx_busy)
    );

    assign lane_oe   = oe_raw & {LANES{~t_q.hold}};
    assign lane_mode = wid;

    // R8
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (lane_oe == '0));

    // R7
    hold_stops_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.hold |=> !rx_valid);

    // R7
    quad_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wid == WID_X4) |-> !t_q.hold);

    // R9
    out_phase_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !cs_n && $past(tx_busy)) |=> !rx_valid);

endmodule

// File: tb/sio_lane_ctrl_test.sv
`timescale 1ns/1ps
module sio_lane_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] lane_in = 4'b1000;
    logic [3:0] lane_out, lane_oe;
    logic [1:0] lane_mode;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_first;
    logic       dout_start = 1'b0;
    logic       dout_dummy = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_take;

    logic [7:0] tx_seed = 8'h00;
    logic       tx_clr = 1'b0;
    int         tx_idx = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         m = 0;

    always #2 clk = ~clk;

    sio_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .lane_in(lane_in),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_mode(lane_mode),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_first(rx_first),
        .dout_start(dout_start), .dout_dummy(dout_dummy),
        .tx_byte(tx_byte), .tx_take(tx_take)
    );

    always @(posedge clk) begin
        if (tx_clr)       tx_idx <= 0;
        else if (tx_take) tx_idx <= tx_idx + 1;
    end
    assign tx_byte = tx_seed + 8'(tx_idx * 37);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] oe_exp(input int w);
        return (w == 2) ? 4'b1111 : (w == 1) ? 4'b0011 : 4'b0010;
    endfunction

    task automatic sck_clock(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] doe,
                             output logic rv, output logic [7:0] rb, output logic rf);
        @(negedge clk); sck = 1'b0; lane_in = din;
        @(negedge clk); @(negedge clk);
        dout = lane_out; doe = lane_oe;
        sck = 1'b1;
        @(negedge clk);
        rv = rx_valid; rb = rx_byte; rf = rx_first;
        @(negedge clk);
    endtask

    task automatic begin_frame(input logic [7:0] seed);
        @(negedge clk); tx_clr = 1'b1; tx_seed = seed; cs_n = 1'b0;
        @(negedge clk); tx_clr = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk); sck = 1'b0; lane_in = 4'b1000;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check("R8 oe released", {28'd0, lane_oe}, 32'd0);
        @(negedge clk);
    endtask

    task automatic chunk_in(input logic [7:0] b, input int i, output logic rv, output logic [7:0] rb,
                            output logic rf);
        logic [7:0] sh;
        logic [3:0] din, o, oe;
        case (m)
            0:       begin sh = b << i;       din = {3'b100, sh[7]}; end
            1:       begin sh = b << (2 * i); din = {2'b10, sh[7:6]}; end
            default: begin sh = b << (4 * i); din = sh[7:4]; end
        endcase
        sck_clock(din, o, oe, rv, rb, rf);
    endtask

    task automatic tx_in(input logic [7:0] b, input logic first, input string req);
        int n;
        logic rv, rf, early;
        logic [7:0] rb;
        n = (m == 2) ? 2 : (m == 1) ? 4 : 8;
        early = 1'b0;
        for (int i = 0; i < n; i++) begin
            chunk_in(b, i, rv, rb, rf);
            if (i < n - 1 && rv) early = 1'b1;
        end
        check(req, {21'd0, early, rv, rf, rb}, {21'd0, 1'b0, 1'b1, first, b});
    endtask

    task automatic start_out(input logic d);
        @(negedge clk); dout_start = 1'b1; dout_dummy = d;
        @(negedge clk); dout_start = 1'b0;
    endtask

    task automatic rx_out(input int skip, input int nbytes, input int first_k, input string req);
        logic [3:0] din, o, oe;
        logic rv, rf, rv_any;
        logic [7:0] rb, got;
        int n;
        din = (m == 2) ? 4'b0000 : 4'b1001;
        n = (m == 2) ? 2 : (m == 1) ? 4 : 8;
        rv_any = 1'b0;
        for (int d = 0; d < skip; d++) begin
            sck_clock(din, o, oe, rv, rb, rf);
            rv_any |= rv;
            check("R6 oe low in dummy", {28'd0, oe}, 32'd0);
        end
        for (int k = 0; k < nbytes; k++) begin
            got = 8'd0;
            for (int c = 0; c < n; c++) begin
                sck_clock(din, o, oe, rv, rb, rf);
                rv_any |= rv;
                case (m)
                    0:       got = {got[6:0], o[1]};
                    1:       got = {got[5:0], o[1:0]};
                    default: got = {got[3:0], o};
                endcase
                if (c == 0) check("R5 oe pattern", {28'd0, oe}, {28'd0, oe_exp(m)});
            end
            check(req, {24'd0, got}, {24'd0, 8'(tx_seed + 8'((first_k + k) * 37))});
        end
        check("R9 no rx in output phase", {31'd0, rv_any}, 32'd0);
    endtask

    task automatic hold_pause(input int n, output logic rv_seen);
        rv_seen = 1'b0;
        @(negedge clk); sck = 1'b0; lane_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 oe low in pause", {28'd0, lane_oe}, 32'd0);
        for (int i = 0; i < n; i++) begin
            lane_in[1:0] = 2'(i);
            sck = 1'b1;
            @(negedge clk); rv_seen |= rx_valid;
            @(negedge clk); sck = 1'b0;
            @(negedge clk); rv_seen |= rx_valid;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic rv, rf, seen;
        logic [7:0] rb;
        logic [3:0] o, oe;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mode", {30'd0, lane_mode}, 32'd0);
        check("R1 oe", {28'd0, lane_oe}, 32'd0);
        check("R1 valid", {31'd0, rx_valid}, 32'd0);

        // R2, R5, R6 single lane read frame
        begin_frame(8'h21);
        tx_in(8'h03, 1'b1, "R2 x1 opcode");
        tx_in(8'h01, 1'b0, "R2 x1 addr");
        tx_in(8'h23, 1'b0, "R2 x1 addr");
        tx_in(8'h45, 1'b0, "R2 x1 addr");
        start_out(1'b1);
        rx_out(0, 3, 0, "R5 x1 data, R6 no dummy");
        check("R5 take count", tx_idx, 3);
        end_frame();

        // R8 partial byte dropped
        begin_frame(8'h00);
        for (int i = 0; i < 3; i++) sck_clock(4'b1001, o, oe, rv, rb, rf);
        end_frame();
        begin_frame(8'h00);
        tx_in(8'h5C, 1'b1, "R8 fresh byte after abort");
        tx_in(8'h3B, 1'b0, "R4 non-first code");
        end_frame();
        check("R4 mode kept", {30'd0, lane_mode}, 32'd0);

        // R3 to two lanes, select raised right after opcode
        begin_frame(8'h00);
        tx_in(8'h3B, 1'b1, "R3 opcode x1");
        end_frame();
        check("R3 mode x2", {30'd0, lane_mode}, 32'd1);
        m = 1;

        begin_frame(8'h11);
        tx_in(8'h38, 1'b1, "R2 x2 opcode");
        check("R4 x4 code ignored in x2", {30'd0, lane_mode}, 32'd1);
        tx_in(8'hC4, 1'b0, "R2 x2 addr");
        tx_in(8'h9E, 1'b0, "R2 x2 addr");
        start_out(1'b1);
        rx_out(4, 1, 0, "R6 x2 data after 4 dummies");
        hold_pause(2, seen);
        rx_out(0, 1, 1, "R7 x2 resume after pause");
        end_frame();

        // R7 pause during reception
        begin_frame(8'h00);
        tx_in(8'h02, 1'b1, "R2 x2 opcode");
        chunk_in(8'hA5, 0, rv, rb, rf);
        chunk_in(8'hA5, 1, rv, rb, rf);
        hold_pause(4, seen);
        check("R7 no byte in pause", {31'd0, seen}, 32'd0);
        chunk_in(8'hA5, 2, rv, rb, rf);
        chunk_in(8'hA5, 3, rv, rb, rf);
        check("R7 byte after resume", {23'd0, rv, rb}, {23'd0, 1'b1, 8'hA5});
        tx_in(8'hFF, 1'b0, "R4 non-first reset code");
        end_frame();
        check("R4 x2 kept", {30'd0, lane_mode}, 32'd1);

        begin_frame(8'h00);
        tx_in(8'hFF, 1'b1, "R4 reset opcode x2");
        end_frame();
        check("R4 back to x1", {30'd0, lane_mode}, 32'd0);
        m = 0;

        begin_frame(8'h00);
        tx_in(8'h38, 1'b1, "R3 opcode x1");
        end_frame();
        check("R3 mode x4", {30'd0, lane_mode}, 32'd2);
        m = 2;

        // R6, R7 four lane read, lane 3 low is data
        begin_frame(8'h7D);
        tx_in(8'h03, 1'b1, "R2 x4 opcode");
        tx_in(8'h70, 1'b0, "R7 lane3 low is data in x4");
        tx_in(8'h06, 1'b0, "R2 x4 addr");
        tx_in(8'h3B, 1'b0, "R2 x4 addr");
        start_out(1'b1);
        rx_out(2, 4, 0, "R6 x4 data after 2 dummies");
        end_frame();
        check("R4 x4 kept", {30'd0, lane_mode}, 32'd2);

        // R2 sweep of every byte value
        begin_frame(8'h00);
        tx_in(8'h02, 1'b1, "R2 x4 opcode");
        for (int v = 0; v < 256; v++) tx_in(8'(v), 1'b0, "R2 x4 sweep");
        end_frame();
        check("R4 x4 kept after data", {30'd0, lane_mode}, 32'd2);

        // R5 long read, no dummy requested
        begin_frame(8'hB3);
        tx_in(8'h03, 1'b1, "R2 x4 opcode");
        tx_in(8'h00, 1'b0, "R2 x4 addr");
        tx_in(8'h10, 1'b0, "R2 x4 addr");
        tx_in(8'h20, 1'b0, "R2 x4 addr");
        start_out(1'b0);
        rx_out(0, 48, 0, "R5 x4 data, R6 no skip");
        end_frame();

        begin_frame(8'h00);
        tx_in(8'hFF, 1'b1, "R4 reset opcode x4");
        end_frame();
        check("R4 x4 to x1", {30'd0, lane_mode}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule